// File: doc/BRIEF.md
# Integer ALU with Shifter

This block is the integer execution unit of a small load/store processor core. It is purely combinational: two operand words, an immediate shift count and a four-bit operation code go in, and a result word and an overflow flag come out in the same cycle. The core's decode stage selects the operation. Any immediate the core needs is sign-extended before it reaches the block.

One adder serves add, subtract and both magnitude compares. A single barrel shifter serves every shift. Its count comes either from the immediate input or from the low bits of the second operand. Arithmetic right shifts copy the sign bit into the vacated positions, so they act as a quick signed divide by a power of two. Only the signed add and the signed subtract can raise the overflow flag. Their unsigned twins produce the same result bits and leave the flag low.

Top module: `alu_core`

## Requirements
- R1: The operation codes are fixed: ADD=0, ADDU=1, SUB=2, SUBU=3, SLT=4, SLTU=5, AND=6, OR=7, XOR=8, NOR=9, SLL=10, SRL=11, SRA=12, SLLV=13, SRLV=14, SRAV=15. ADD and ADDU return a+b modulo 2^W. SUB and SUBU return a-b modulo 2^W.
- R2: For ADD, overflow_o is 1 exactly when both operands share a sign and the sum's sign differs from it. For SUB, the same test is applied to a and the negated b. Example: 0x7FFFFFFF+1 and 0x80000000-1 both raise it.
- R3: overflow_o is 0 for every code other than ADD and SUB. This includes ADDU and SUBU on operands that would overflow when treated as signed.
- R4: SLT returns 1 when a is less than b as two's-complement numbers, and 0 otherwise, with all upper bits zero. 0xFFFFFFFF against 1 gives 1.
- R5: SLTU returns 1 when a is less than b as unsigned numbers, and 0 otherwise, with all upper bits zero. 0xFFFFFFFF against 1 gives 0.
- R6: AND, OR, XOR and NOR combine a and b independently in every bit position.
- R7: SLL shifts a left by shamt_i and fills the vacated low bits with zeros. 8 shifted by 2 gives 32.
- R8: SRL shifts a right by shamt_i and fills the vacated high bits with zeros.
- R9: SRA shifts a right by shamt_i and fills the vacated high bits with a's sign bit. 0xFFFFFFF0 shifted by 2 gives 0xFFFFFFFC.
- R10: SLLV, SRLV and SRAV behave like SLL, SRL and SRA, but take the count from the low log2(W) bits of b. The higher bits of b are ignored. -128 shifted by SRAV with b=4 gives -8.
- R11: A shift count of 0 returns a unchanged. shamt_i has no effect on the three variable-count shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand; the value that is shifted |
| b_i | input | W | Second operand; its low bits give the count for variable shifts |
| shamt_i | input | log2(W) | Immediate shift count |
| op_i | input | 4 | Operation code (encoding in R1) |
| result_o | output | W | Result word |
| overflow_o | output | 1 | Signed add/subtract overflow |

## Verification
The bench builds two copies of the block. The first uses the default W=32, where the directed cases exercise the listed example values, full-width shifts and the sign-boundary operands. The second uses W=8. At that width every one of the 65,536 operand pairs can be applied to ADD, SUB, SLT and SLTU. Each output is then compared with a reference computed from integer arithmetic, which covers every overflow and compare corner, including signed compares whose internal subtraction overflows.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_SLT  = 4'd4,
        OP_SLTU = 4'd5,
        OP_AND  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_NOR  = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_SLLV = 4'd13,
        OP_SRLV = 4'd14,
        OP_SRAV = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_CMP,
        UNIT_LOGIC,
        UNIT_SHIFT
    } unit_e;

    typedef struct packed {
        logic subtract;
        logic signed_ovf;
        logic unsigned_cmp;
    } arith_ctl_t;

    typedef struct packed {
        logic right;
        logic arith;
        logic from_reg;
    } shift_ctl_t;

    function automatic unit_e unit_of(alu_op_e op);
        unit_e u;
        case (op)
            OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: u = UNIT_ARITH;
            OP_SLT, OP_SLTU:                  u = UNIT_CMP;
            OP_AND, OP_OR, OP_XOR, OP_NOR:    u = UNIT_LOGIC;
            default:                          u = UNIT_SHIFT;
        endcase
        return u;
    endfunction

    function automatic arith_ctl_t arith_ctl(alu_op_e op);
        arith_ctl_t c;
        c.subtract     = (op == OP_SUB) || (op == OP_SUBU) ||
                         (op == OP_SLT) || (op == OP_SLTU);
        c.signed_ovf   = (op == OP_ADD) || (op == OP_SUB);
        c.unsigned_cmp = (op == OP_SLTU);
        return c;
    endfunction

    function automatic shift_ctl_t shift_ctl(alu_op_e op);
        shift_ctl_t c;
        c.right    = (op == OP_SRL) || (op == OP_SRA) ||
                     (op == OP_SRLV) || (op == OP_SRAV);
        c.arith    = (op == OP_SRA) || (op == OP_SRAV);
        c.from_reg = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] sum_o,
    output logic         lt_o,
    output logic         ovf_o
);

    arith_ctl_t   ctl;
    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic [W-1:0] sum;
    logic         carry;
    logic         raw_ovf;

    always_comb begin
        op      = alu_op_e'(op_i);
        ctl     = arith_ctl(op);
        b_eff   = ctl.subtract ? ~b_i : b_i;
        {carry, sum} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, ctl.subtract};
        raw_ovf = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
        ovf_o   = raw_ovf && ctl.signed_ovf;
        lt_o    = ctl.unsigned_cmp ? ~carry : (sum[W-1] ^ raw_ovf);
        sum_o   = sum;

        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op == OP_ADDU || op == OP_SUBU)
                AST_NO_OVERFLOW_UNSIGNED: assert (!ovf_o); // R3
            if (ovf_o)
                AST_OVERFLOW_SIGN_FLIP: assert (sum_o[W-1] != a_i[W-1]); // R2
            if (op == OP_SLT)
                AST_SLT_SIGNED: assert (lt_o == ($signed(a_i) < $signed(b_i))); // R4
            if (op == OP_SLTU)
                AST_SLT_UNSIGNED: assert (lt_o == (a_i < b_i)); // R5
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o
);

    alu_op_e op;

    always_comb begin
        op = alu_op_e'(op_i);
        case (op)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_NOR:  res_o = ~(a_i | b_i);
            default: res_o = '0;
        endcase

        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op == OP_NOR)
                AST_NOR_DISJOINT: assert ((res_o & (a_i | b_i)) == '0); // R6
            if (op == OP_AND)
                AST_AND_SUBSET: assert ((res_o & ~(a_i & b_i)) == '0 && (res_o | ~a_i) == (b_i | ~a_i)); // R6
        end
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter  int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_reg_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic [3:0]     op_i,
    output logic [W-1:0]   res_o
);

    alu_op_e        op;
    shift_ctl_t     ctl;
    logic [SHW-1:0] amt;
    logic           fill;
    logic [W-1:0]   val;
    logic [W-1:0]   rev_in;
    logic [W-1:0]   rev_out;

    always_comb begin
        op   = alu_op_e'(op_i);
        ctl  = shift_ctl(op);
        amt  = ctl.from_reg ? amt_reg_i : shamt_i;
        fill = ctl.arith & a_i[W-1];
        for (int i = 0; i < W; i++) rev_in[i] = a_i[W-1-i];
        val = ctl.right ? a_i : rev_in;
        // log2(W) stages, stage k moves by 2^k
        for (int k = 0; k < SHW; k++) begin
            if (amt[k])
                val = (val >> (1 << k)) | (fill ? ~({W{1'b1}} >> (1 << k)) : '0);
        end
        for (int i = 0; i < W; i++) rev_out[i] = val[W-1-i];
        res_o = ctl.right ? val : rev_out;

        if (!$isunknown({a_i, amt_reg_i, shamt_i, op_i})) begin
            if (op == OP_SLL || op == OP_SLLV)
                AST_LEFT_ZERO_FILL: assert ((res_o & ~({W{1'b1}} << amt)) == '0); // R7
            if (op == OP_SRL || op == OP_SRLV)
                AST_RIGHT_ZERO_FILL: assert ((res_o & ~({W{1'b1}} >> amt)) == '0); // R8
            if (op == OP_SRA || op == OP_SRAV)
                AST_SIGN_KEPT: assert (res_o[W-1] == a_i[W-1]); // R9
            if ((op == OP_SLL || op == OP_SRL || op == OP_SRA || op == OP_SLLV ||
                 op == OP_SRLV || op == OP_SRAV) && amt == '0)
                AST_ZERO_COUNT_PASS: assert (res_o == a_i); // R11
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter  int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic [3:0]     op_i,
    output logic [W-1:0]   result_o,
    output logic           overflow_o
);

    logic [W-1:0] sum;
    logic         lt;
    logic         ovf;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    unit_e        unit;

    alu_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .sum_o (sum),
        .lt_o  (lt),
        .ovf_o (ovf)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_i),
        .res_o (logic_res)
    );

    alu_shift #(.W(W)) u_shift (
        .a_i       (a_i),
        .amt_reg_i (b_i[SHW-1:0]),
        .shamt_i   (shamt_i),
        .op_i      (op_i),
        .res_o     (shift_res)
    );

    always_comb begin
        unit = unit_of(alu_op_e'(op_i));
        case (unit)
            UNIT_ARITH: result_o = sum;
            UNIT_CMP:   result_o = {{(W-1){1'b0}}, lt};
            UNIT_LOGIC: result_o = logic_res;
            default:    result_o = shift_res;
        endcase
        overflow_o = ovf;
    end

endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    import alu_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4ns clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] a, b, res;
    logic [4:0]  sh;
    logic [3:0]  op;
    logic        ovf;

    logic [7:0]  a8, b8, res8;
    logic [2:0]  sh8;
    logic [3:0]  op8;
    logic        ovf8;

    alu_core dut (
        .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res), .overflow_o(ovf)
    );

    alu_core #(.W(8)) dut8 (
        .a_i(a8), .b_i(b8), .shamt_i(sh8), .op_i(op8), .result_o(res8), .overflow_o(ovf8)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic run(input alu_op_e o, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s);
        @(negedge clk);
        op = o; a = x; b = y; sh = s;
        #2ns;
    endtask

    task automatic t_reset;
        op = OP_ADD; a = '0; b = '0; sh = '0;
        op8 = OP_ADD; a8 = '0; b8 = '0; sh8 = '0;
        repeat (3) @(posedge clk);
        #1ns;
        chk("R1 reset-state result", res, 32'h0);
        chk("R3 reset-state overflow", {31'b0, ovf}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_addsub;
        run(OP_ADD, 32'd5, 32'd7, 5'd0);
        chk("R1 add", res, 32'd12);
        chk("R2 add no overflow", {31'b0, ovf}, 32'h0);
        run(OP_ADDU, 32'hFFFF_FFFF, 32'd1, 5'd0);
        chk("R1 addu wrap", res, 32'h0);
        run(OP_SUB, 32'd10, 32'd3, 5'd0);
        chk("R1 sub", res, 32'd7);
        run(OP_ADD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0);
        chk("R1 add negatives", res, 32'hFFFF_FFFE);
        chk("R2 add negatives no overflow", {31'b0, ovf}, 32'h0);
    endtask

    task automatic t_overflow;
        run(OP_ADD, 32'h7FFF_FFFF, 32'd1, 5'd0);
        chk("R1 add sum bits", res, 32'h8000_0000);
        chk("R2 add overflow", {31'b0, ovf}, 32'h1);
        run(OP_SUB, 32'h8000_0000, 32'd1, 5'd0);
        chk("R2 sub overflow", {31'b0, ovf}, 32'h1);
        run(OP_SUBU, 32'h8000_0000, 32'd1, 5'd0);
        chk("R1 subu result", res, 32'h7FFF_FFFF);
        chk("R3 subu no overflow", {31'b0, ovf}, 32'h0);
        run(OP_ADDU, 32'h7FFF_FFFF, 32'd1, 5'd0);
        chk("R3 addu no overflow", {31'b0, ovf}, 32'h0);
        run(OP_SLT, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
        chk("R3 slt no overflow", {31'b0, ovf}, 32'h0);
    endtask

    task automatic t_compare;
        run(OP_SLT, 32'hFFFF_FFFF, 32'd1, 5'd0);
        chk("R4 slt -1<1", res, 32'd1);
        run(OP_SLTU, 32'hFFFF_FFFF, 32'd1, 5'd0);
        chk("R5 sltu max<1", res, 32'd0);
        run(OP_SLT, 32'd1, 32'd1, 5'd0);
        chk("R4 slt equal", res, 32'd0);
        run(OP_SLTU, 32'd1, 32'hFFFF_FFFF, 5'd0);
        chk("R5 sltu 1<max", res, 32'd1);
        run(OP_SLT, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0);
        chk("R4 slt min<max", res, 32'd1);
    endtask

    task automatic t_logic;
        run(OP_AND, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
        chk("R6 and", res, 32'h00F0_1200);
        run(OP_OR, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
        chk("R6 or", res, 32'hFFF0_FF34);
        run(OP_XOR, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
        chk("R6 xor", res, 32'hFF00_ED34);
        chk("R3 xor no overflow", {31'b0, ovf}, 32'h0);
        run(OP_NOR, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0);
        chk("R6 nor", res, 32'h000F_00CB);
    endtask

    task automatic t_shift_imm;
        run(OP_SLL, 32'd8, 32'hFFFF_FFFF, 5'd2);
        chk("R7 sll 8 by 2", res, 32'd32);
        run(OP_SLL, 32'h8000_0001, 32'd0, 5'd1);
        chk("R7 sll zero fill", res, 32'h0000_0002);
        run(OP_SRL, 32'hFFFF_FFF0, 32'd0, 5'd2);
        chk("R8 srl zero fill", res, 32'h3FFF_FFFC);
        run(OP_SRA, 32'hFFFF_FFF0, 32'd0, 5'd2);
        chk("R9 sra -16 by 2", res, 32'hFFFF_FFFC);
        run(OP_SRA, 32'h8000_0000, 32'd0, 5'd31);
        chk("R9 sra full negative", res, 32'hFFFF_FFFF);
        run(OP_SRA, 32'h7FFF_0000, 32'd0, 5'd31);
        chk("R9 sra full positive", res, 32'h0);
        run(OP_SRA, 32'h8000_0005, 32'd0, 5'd0);
        chk("R11 zero count passes", res, 32'h8000_0005);
    endtask

    task automatic t_shift_var;
        run(OP_SRAV, 32'hFFFF_FF80, 32'd4, 5'd7);
        chk("R10 srav -128 by 4", res, 32'hFFFF_FFF8);
        run(OP_SLLV, 32'd1, 32'hFFFF_FFE3, 5'd0);
        chk("R10 sllv upper b ignored", res, 32'd8);
        run(OP_SRLV, 32'h8000_0000, 32'd31, 5'd1);
        chk("R10 srlv by 31", res, 32'd1);
        run(OP_SLLV, 32'h0000_1234, 32'd32, 5'd9);
        chk("R11 variable zero count, shamt ignored", res, 32'h0000_1234);
    endtask

    task automatic t_narrow_sweep;
        int bad_add = 0, bad_sub = 0, bad_slt = 0, bad_sltu = 0;
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [7:0] xv, yv;
                int sx, sy, s;
                logic e_ovf;
                xv = x[7:0]; yv = y[7:0];
                sx = int'($signed(xv)); sy = int'($signed(yv));
                a8 = xv; b8 = yv;
                op8 = OP_ADD; #1ns;
                s = sx + sy; e_ovf = (s > 127) || (s < -128);
                if (res8 !== 8'(x + y) || ovf8 !== e_ovf) bad_add++;
                op8 = OP_SUB; #1ns;
                s = sx - sy; e_ovf = (s > 127) || (s < -128);
                if (res8 !== 8'(x - y) || ovf8 !== e_ovf) bad_sub++;
                op8 = OP_SLT; #1ns;
                if (res8 !== ((sx < sy) ? 8'd1 : 8'd0) || ovf8 !== 1'b0) bad_slt++;
                op8 = OP_SLTU; #1ns;
                if (res8 !== ((x < y) ? 8'd1 : 8'd0) || ovf8 !== 1'b0) bad_sltu++;
            end
        end
        chk("R2 narrow add mismatches", 32'(bad_add), 32'd0);
        chk("R2 narrow sub mismatches", 32'(bad_sub), 32'd0);
        chk("R4 narrow slt mismatches", 32'(bad_slt), 32'd0);
        chk("R5 narrow sltu mismatches", 32'(bad_sltu), 32'd0);
    endtask

    initial begin
        t_reset();
        t_addsub();
        t_overflow();
        t_compare();
        t_logic();
        t_shift_imm();
        t_shift_var();
        t_narrow_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule